// File: doc/BRIEF.md
# Dynamic Loss Scale Controller

This block keeps the loss-scale factor used in mixed-precision training. The scale is held as a power-of-two exponent: a scale of 2^E multiplies the loss before the backward pass, and the same factor divides the gradients before the weight update. External logic reports the end of each training step with a one-cycle `step_valid` pulse and raises `step_overflow` in that cycle if any gradient came out infinite or NaN. Finding the bad gradients, scaling them and updating the weights all happen outside this block.

The scale moves unevenly. A single overflowing step lowers the exponent by one at once and marks that step's update for skipping. Raising the exponent by one takes a run of clean steps, counted against a programmable 16-bit interval. Programmable lower and upper bounds clamp the exponent, and it never wraps. An interval of zero stops the scale from growing. Step reports are plain control pulses, not a stream. There is no back-pressure, and the block takes a report in any cycle, including back-to-back cycles.

Top module: `loss_scale_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `scale_exp` equals the parameter `RESET_EXP` (default 10, a scale of 1024), and the clean-run count is zero.
- R2: `skip_update` is high in exactly those cycles where `step_valid` and `step_overflow` are both high. It is combinational, so it is high in the same cycle as the report and in no other.
- R3: On an overflowing step with `scale_exp` above `cfg_min_exp`, `scale_exp` is one lower in the next cycle.
- R4: An overflowing step clears the clean-run count. The next increase then needs a full fresh run of `cfg_interval` clean steps.
- R5: If `cfg_interval` is N > 0, the N-th consecutive clean step (step_valid high, step_overflow low) raises `scale_exp` by one in the next cycle and clears the count.
- R6: `scale_exp` never goes below `cfg_min_exp` through an overflow, and never goes above `cfg_max_exp` through growth. A run that completes at the upper bound still clears the count.
- R7: With `cfg_interval` = 0, clean steps never raise `scale_exp`.
- R8: In cycles without `step_valid`, `scale_exp` and the clean-run count hold their values. Idle cycles between steps do not break a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_valid | input | 1 | One-cycle pulse: a training step has finished |
| step_overflow | input | 1 | Qualifies step_valid: some gradient was inf or NaN |
| cfg_interval | input | 16 | Clean steps needed for one increase; 0 disables growth |
| cfg_min_exp | input | 6 | Lowest allowed exponent |
| cfg_max_exp | input | 6 | Highest allowed exponent |
| scale_exp | output | 6 | Current scale exponent (scale = 2^scale_exp) |
| skip_update | output | 1 | The step reported this cycle must not update weights |

## Verification
`skip_update` is due in the same cycle as the step report, and a change to `scale_exp` is due in the first cycle after the clock edge that captured the report. The bench drives inputs shortly after each rising edge and samples on the falling edge. At that point `skip_update` reflects the inputs already applied, and `scale_exp` reflects every edge before it. A behavioural reference model advances on each rising edge, and its value is compared with the outputs on every falling edge. It covers reset, growth runs broken by overflows, idle gaps, saturation at both bounds, and the zero and one interval settings.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int EXP_W = 6;
  localparam int CNT_W = 16;
  typedef logic [EXP_W-1:0] exp_t;
  typedef logic [CNT_W-1:0] cnt_t;
  typedef enum logic [1:0] {ADJ_HOLD, ADJ_DOWN, ADJ_UP} adj_e;
endpackage

// File: rtl/lsc_run_counter.sv
module lsc_run_counter
  import lsc_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clean_step,
  input  logic         bad_step,
  input  logic [W-1:0] interval,
  output logic         run_done
);
  localparam int SUM_W = W + 1;

  logic [W-1:0]     count_q;
  logic [SUM_W-1:0] next_count;
  logic             enabled;

  assign enabled    = (interval != '0);
  assign next_count = {1'b0, count_q} + SUM_W'(1);
  // ">=" also covers an interval that was lowered below the current count
  assign run_done   = clean_step && enabled && (next_count >= {1'b0, interval});

  always_ff @(posedge clk) begin
    if (!rst_n)                     count_q <= '0;
    else if (bad_step || run_done)  count_q <= '0;
    else if (clean_step && enabled) count_q <= next_count[W-1:0];
  end
endmodule

// File: rtl/lsc_exp_reg.sv
module lsc_exp_reg
  import lsc_pkg::*;
#(
  parameter int W         = EXP_W,
  parameter int RESET_VAL = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  adj_e         adj,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] value
);
  logic [W-1:0] value_q;
  logic [W-1:0] value_d;

  always_comb begin
    value_d = value_q;
    unique case (adj)
      ADJ_DOWN: if (value_q > lo) value_d = value_q - W'(1);
      ADJ_UP:   if (value_q < hi) value_d = value_q + W'(1);
      default:  value_d = value_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) value_q <= W'(RESET_VAL);
    else        value_q <= value_d;
  end

  assign value = value_q;
endmodule

// File: rtl/loss_scale_ctrl.sv
module loss_scale_ctrl
  import lsc_pkg::*;
#(
  parameter int RESET_EXP = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_valid,
  input  logic             step_overflow,
  input  logic [CNT_W-1:0] cfg_interval,
  input  logic [EXP_W-1:0] cfg_min_exp,
  input  logic [EXP_W-1:0] cfg_max_exp,
  output logic [EXP_W-1:0] scale_exp,
  output logic             skip_update
);
  logic bad_step;
  logic clean_step;
  logic run_done;
  adj_e adj;

  assign bad_step   = step_valid & step_overflow;
  assign clean_step = step_valid & ~step_overflow;

  lsc_run_counter #(.W(CNT_W)) u_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .clean_step (clean_step),
    .bad_step   (bad_step),
    .interval   (cfg_interval),
    .run_done   (run_done)
  );

  always_comb begin
    if (bad_step)      adj = ADJ_DOWN;
    else if (run_done) adj = ADJ_UP;
    else               adj = ADJ_HOLD;
  end

  lsc_exp_reg #(.W(EXP_W), .RESET_VAL(RESET_EXP)) u_exp (
    .clk   (clk),
    .rst_n (rst_n),
    .adj   (adj),
    .lo    (cfg_min_exp),
    .hi    (cfg_max_exp),
    .value (scale_exp)
  );

  assign skip_update = bad_step;
endmodule

// File: rtl/loss_scale_ctrl_checker.sv
module loss_scale_ctrl_checker
  import lsc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             step_valid,
  input logic             step_overflow,
  input logic [CNT_W-1:0] cfg_interval,
  input logic [EXP_W-1:0] cfg_min_exp,
  input logic [EXP_W-1:0] cfg_max_exp,
  input logic [EXP_W-1:0] scale_exp,
  input logic             skip_update
);
  assert_skip_needs_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    skip_update |-> step_valid);

  assert_overflow_lowers_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_update && scale_exp > cfg_min_exp) |=> scale_exp == $past(scale_exp) - 1'b1);

  assert_floor_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_update && scale_exp <= cfg_min_exp) |=> $stable(scale_exp));

  assert_ceiling_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !step_overflow && scale_exp >= cfg_max_exp) |=> $stable(scale_exp));

  assert_no_growth_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !step_overflow && cfg_interval == '0) |=> $stable(scale_exp));

  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !step_valid |=> $stable(scale_exp));
endmodule

bind loss_scale_ctrl loss_scale_ctrl_checker u_chk (.*);

// File: tb/loss_scale_ctrl_bench.sv
module loss_scale_ctrl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        step_valid = 0;
  logic        step_overflow = 0;
  logic [15:0] cfg_interval = 16'd4;
  logic [5:0]  cfg_min_exp = 6'd0;
  logic [5:0]  cfg_max_exp = 6'd40;
  logic [5:0]  scale_exp;
  logic        skip_update;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int m_exp = 10;
  int m_cnt = 0;
  string m_tag = "R1";

  always #4 clk = ~clk;

  loss_scale_ctrl u_loss_scale_ctrl (.*);

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_exp = 10; m_cnt = 0; m_tag = "R1";
    end else if (step_valid && step_overflow) begin
      m_cnt = 0;
      if (m_exp > cfg_min_exp) begin m_exp--; m_tag = "R3"; end
      else m_tag = "R6";
    end else if (step_valid) begin
      if (cfg_interval == 0) m_tag = "R7";
      else begin
        m_cnt++;
        m_tag = "R4";
        if (m_cnt >= cfg_interval) begin
          m_cnt = 0;
          if (m_exp < cfg_max_exp) begin m_exp++; m_tag = "R5"; end
          else m_tag = "R6";
        end
      end
    end else if (m_tag != "R1") m_tag = "R8";
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (scale_exp !== 6'(m_exp)) begin
        errors++;
        $display("FAIL %s scale_exp actual=%0d expected=%0d t=%0t", m_tag, scale_exp, m_exp, $time);
      end
      checks++;
      if (skip_update !== (step_valid && step_overflow)) begin
        errors++;
        $display("FAIL R2 skip_update actual=%0b expected=%0b t=%0t", skip_update,
                 step_valid && step_overflow, $time);
      end
    end
  end

  task automatic step(input bit ovf);
    @(posedge clk); #2 step_valid = 1; step_overflow = ovf;
    @(posedge clk); #2 step_valid = 0; step_overflow = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    idle(3);
    rst_n = 1;                                       // R1 checked while held and after
    idle(2);
    for (int i = 0; i < 4; i++) step(0);             // R5: 10 -> 11
    step(1);                                         // R2, R3: 11 -> 10
    for (int i = 0; i < 3; i++) step(0);
    step(1);                                         // R4: run broken, 10 -> 9
    for (int i = 0; i < 3; i++) step(0);             // no growth yet
    for (int i = 0; i < 4; i++) begin step(0); idle(3); end // R8: gaps keep run
    cfg_min_exp = 6'd7;
    for (int i = 0; i < 6; i++) step(1);             // R6 floor at 7
    cfg_interval = 16'd1; cfg_max_exp = 6'd9;
    for (int i = 0; i < 5; i++) step(0);             // R5 each step, R6 ceiling 9
    cfg_interval = 16'd0; cfg_max_exp = 6'd40;
    for (int i = 0; i < 10; i++) step(0);            // R7
    step(1);
    cfg_interval = 16'd2;
    @(posedge clk); #2 step_valid = 1; step_overflow = 0;   // back-to-back steps
    @(posedge clk); #2 step_overflow = 1;
    @(posedge clk); #2 step_overflow = 0;
    @(posedge clk); #2 step_valid = 0;
    idle(2);
    rst_n = 0; idle(2); rst_n = 1; idle(2);          // R1 again
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule